// File: doc/BRIEF.md
# Serial Command and Display Memory Front End for a Multiplexed LCD Driver

This block is the host-facing half of a segment/common LCD driver. A host shifts bytes in over a three-wire link: an active-low strobe frames a transfer, and a data bit is taken on every rising edge of the shift clock while the strobe is low. The first complete byte after the strobe falls is a command. Every byte after it in the same strobe window is display data and goes into a small display memory of group addresses.

Four command types set the display mode, the data-write behaviour, the status flags and the current group address. The group-address counter can advance after each data byte and wraps to zero at a limit that follows the selected duty. The flags and a second read port on the display memory feed the frame-timing and output-latch logic next to this block. Any strobe edge resets the receiver. A strobe edge that lands while a byte waits for decode, or while the latch logic reports a latch in progress, cancels that work and turns the display flag off.

All pins are taken as already synchronous to `clk`.

Top module: `lcd_host_if`

## Requirements
- R1: After reset every flag and code output is 0, `grp_addr` is 0 and `data_seen` is 0.
- R2: `sdin` is shifted in MSB first on each rising edge of `sclk` while `stb_n` is low. Shift-clock edges while `stb_n` is high change nothing.
- R3: The first full byte after `stb_n` falls is a command. Bits [7:6] pick the type: 00 mode, 01 data setting, 10 status, 11 address. Bits a command does not use are ignored.
- R4: Mode command: bits [3:2] load `frame_code` and bits [1:0] load `duty_code`.
- R5: Data-setting command: bit 3 loads `latch_mode`, bit 2 loads `addr_hold`, bits [1:0] load `wr_mode`. While `wr_mode[1]` is 1, data bytes neither change memory nor move `grp_addr`.
- R6: Status command: bits [5:4] load `link_mode`, bit 3 `int_bias`, bit 2 `addr_rst_en`, bit 1 `latch_flag`, bit 0 `disp_on`.
- R7: Address command: bits [5:0] load `grp_addr`. A value above the limit for the current duty loads 0 instead. The limit is 14 for duty codes 00/01, 19 for 10 and 29 for 11.
- R8: Each data byte is written at `grp_addr`. `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is applied.
- R9: After a data write, `grp_addr` goes up by one when `addr_hold` is 0, or to 0 if it was at or above the duty limit. When `addr_hold` is 1 it stays.
- R10: On a rising `stb_n`, `grp_addr` clears to 0 if `addr_rst_en` is 1 and a data byte was written in that strobe window.
- R11: Bits of an unfinished byte are thrown away at any `stb_n` edge.
- R12: A `stb_n` edge in the cycle a received byte waits for decode discards that byte and clears `disp_on`. A `stb_n` edge while `latch_busy` is high also clears `disp_on`.
- R13: `data_seen` goes high after a data byte is written and drops at the next `stb_n` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_n | input | 1 | Active-low transfer strobe |
| sclk | input | 1 | Shift clock, sampled on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| latch_busy | input | 1 | High while the latch logic copies the display memory |
| rd_addr | input | 6 | Display memory read address for the scan logic |
| rd_data | output | 8 | Display memory byte, one cycle after `rd_addr` |
| frame_code | output | 2 | Frame-rate divider code |
| duty_code | output | 2 | Duty and bias code |
| latch_mode | output | 1 | Latch after data transfers |
| addr_hold | output | 1 | Keep the address after data bytes |
| wr_mode | output | 2 | Write mode; 1x blocks writes |
| link_mode | output | 2 | Multi-chip role and test selection |
| int_bias | output | 1 | Use the internal drive-voltage divider |
| addr_rst_en | output | 1 | Clear the address at strobe rise after a write |
| latch_flag | output | 1 | Latch on every strobe rise |
| disp_on | output | 1 | Display enable flag |
| grp_addr | output | 6 | Current group address |
| data_seen | output | 1 | A data byte was written in this strobe window |

## Verification
The hardest case to reach from the pins is the one-cycle window between the eighth shift-clock edge and command decode. A strobe edge must land inside it to prove that the received byte is dropped and the display flag falls. The bench cuts its last bit short by one clock and raises the strobe at the next falling clock edge, so the edge coincides with the pending decode. The partial-byte case is also checked by misalignment: it sends five stray bits and then a status command whose result would differ if those bits survived.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  localparam int LIM_D2 = 14;
  localparam int LIM_D3 = 19;
  localparam int LIM_D4 = 29;

  typedef enum logic [1:0] {
    CMD_MODE = 2'b00,
    CMD_DATA = 2'b01,
    CMD_STAT = 2'b10,
    CMD_ADDR = 2'b11
  } cmd_e;

  function automatic logic [5:0] lim_for(input logic [1:0] duty);
    if (!duty[1]) return 6'(LIM_D2);
    else if (!duty[0]) return 6'(LIM_D3);
    else return 6'(LIM_D4);
  endfunction
endpackage

// File: rtl/lcd_ser_rx.sv
module lcd_ser_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  logic          sclk,
  input  logic          sdin,
  output logic          stb_edge,
  output logic          stb_rise,
  output logic          byte_vld,
  output logic [BW-1:0] byte_q,
  output logic          byte_cmd
);
  localparam int CW = $clog2(BW);

  logic          stb_q, sclk_q, first, shift_en;
  logic [BW-2:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    stb_q  <= stb_n;
    sclk_q <= sclk;
  end

  assign stb_edge = stb_n ^ stb_q;
  assign stb_rise = stb_n & ~stb_q;
  assign shift_en = sclk & ~sclk_q & ~stb_n & ~stb_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      first    <= 1'b1;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      byte_cmd <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (stb_edge) begin
        cnt   <= '0;
        first <= 1'b1;
      end else if (shift_en) begin
        sh <= {sh[BW-3:0], sdin};
        if (cnt == CW'(BW-1)) begin
          byte_vld <= 1'b1;
          byte_q   <= {sh, sdin};
          byte_cmd <= first;
          first    <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
  import lcd_host_pkg::*;
#(
  parameter int BW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_edge,
  input  logic          stb_rise,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_q,
  input  logic          byte_cmd,
  input  logic          latch_busy,
  output logic [1:0]    frame_code,
  output logic [1:0]    duty_code,
  output logic          latch_mode,
  output logic          addr_hold,
  output logic [1:0]    wr_mode,
  output logic [1:0]    link_mode,
  output logic          int_bias,
  output logic          addr_rst_en,
  output logic          latch_flag,
  output logic          disp_on,
  output logic [AW-1:0] grp_addr,
  output logic          data_seen,
  output logic          ram_we,
  output logic [AW-1:0] ram_wa,
  output logic [BW-1:0] ram_wd
);
  logic          live, cmd_ok;
  logic [AW-1:0] lim, nxt, ld_addr;

  assign live    = byte_vld & ~stb_edge;
  assign cmd_ok  = live & byte_cmd;
  assign ram_we  = live & ~byte_cmd & ~wr_mode[1];
  assign ram_wa  = grp_addr;
  assign ram_wd  = byte_q;
  assign lim     = AW'(lim_for(duty_code));
  assign nxt     = addr_hold ? grp_addr : ((grp_addr >= lim) ? '0 : grp_addr + 1'b1);
  assign ld_addr = (AW'(byte_q[5:0]) > lim) ? '0 : AW'(byte_q[5:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_code  <= '0;
      duty_code   <= '0;
      latch_mode  <= 1'b0;
      addr_hold   <= 1'b0;
      wr_mode     <= '0;
      link_mode   <= '0;
      int_bias    <= 1'b0;
      addr_rst_en <= 1'b0;
      latch_flag  <= 1'b0;
      disp_on     <= 1'b0;
      grp_addr    <= '0;
      data_seen   <= 1'b0;
    end else begin
      if (stb_edge && (byte_vld || latch_busy)) disp_on <= 1'b0;
      if (stb_edge) data_seen <= 1'b0;
      if (stb_rise && addr_rst_en && data_seen) grp_addr <= '0;
      if (cmd_ok) begin
        case (cmd_e'(byte_q[BW-1:BW-2]))
          CMD_MODE: begin
            frame_code <= byte_q[3:2];
            duty_code  <= byte_q[1:0];
          end
          CMD_DATA: begin
            latch_mode <= byte_q[3];
            addr_hold  <= byte_q[2];
            wr_mode    <= byte_q[1:0];
          end
          CMD_STAT: begin
            link_mode   <= byte_q[5:4];
            int_bias    <= byte_q[3];
            addr_rst_en <= byte_q[2];
            latch_flag  <= byte_q[1];
            disp_on     <= byte_q[0];
          end
          default: grp_addr <= ld_addr;
        endcase
      end
      if (ram_we) begin
        grp_addr  <= nxt;
        data_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int BW    = 8,
  parameter int AW    = 6,
  parameter int DEPTH = 30
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [BW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [BW-1:0] rd
);
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(wa) < DEPTH)) mem[wa] <= wd;
    rd <= (int'(ra) < DEPTH) ? mem[ra] : '0;
  end
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if #(
  parameter int BW    = 8,
  parameter int AW    = 6,
  parameter int DEPTH = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  logic          sclk,
  input  logic          sdin,
  input  logic          latch_busy,
  input  logic [AW-1:0] rd_addr,
  output logic [BW-1:0] rd_data,
  output logic [1:0]    frame_code,
  output logic [1:0]    duty_code,
  output logic          latch_mode,
  output logic          addr_hold,
  output logic [1:0]    wr_mode,
  output logic [1:0]    link_mode,
  output logic          int_bias,
  output logic          addr_rst_en,
  output logic          latch_flag,
  output logic          disp_on,
  output logic [AW-1:0] grp_addr,
  output logic          data_seen
);
  logic          stb_edge, stb_rise, byte_vld, byte_cmd, ram_we;
  logic [BW-1:0] byte_q, ram_wd;
  logic [AW-1:0] ram_wa;

  lcd_ser_rx #(.BW(BW)) u_rx (
    .clk(clk), .rst(rst), .stb_n(stb_n), .sclk(sclk), .sdin(sdin),
    .stb_edge(stb_edge), .stb_rise(stb_rise), .byte_vld(byte_vld),
    .byte_q(byte_q), .byte_cmd(byte_cmd)
  );

  lcd_cmd_regs #(.BW(BW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .stb_edge(stb_edge), .stb_rise(stb_rise),
    .byte_vld(byte_vld), .byte_q(byte_q), .byte_cmd(byte_cmd),
    .latch_busy(latch_busy), .frame_code(frame_code), .duty_code(duty_code),
    .latch_mode(latch_mode), .addr_hold(addr_hold), .wr_mode(wr_mode),
    .link_mode(link_mode), .int_bias(int_bias), .addr_rst_en(addr_rst_en),
    .latch_flag(latch_flag), .disp_on(disp_on), .grp_addr(grp_addr),
    .data_seen(data_seen), .ram_we(ram_we), .ram_wa(ram_wa), .ram_wd(ram_wd)
  );

  lcd_disp_ram #(.BW(BW), .AW(AW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .wa(ram_wa), .wd(ram_wd), .ra(rd_addr), .rd(rd_data)
  );
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk
  import lcd_host_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          stb_n,
  input logic          latch_busy,
  input logic          disp_on,
  input logic [13:0]   cfg,
  input logic [AW-1:0] grp_addr,
  input logic [1:0]    duty_code,
  input logic          addr_hold,
  input logic [1:0]    wr_mode,
  input logic          ram_we
);
  // R2
  quiet_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_n && $past(stb_n) && $past(stb_n, 2)) |-> ($stable(cfg) && $stable(grp_addr)));

  // R6
  on_from_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_on) |-> !$past(stb_n));

  // R12
  busy_abort_chk: assert property (@(posedge clk) disable iff (rst)
    ((stb_n != $past(stb_n)) && latch_busy) |=> !disp_on);

  // R9
  addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !addr_hold && (grp_addr >= AW'(lim_for(duty_code)))) |=> (grp_addr == '0));

  // R5
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_mode[1] |-> !ram_we);
endmodule

bind lcd_host_if lcd_host_if_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .stb_n(stb_n), .latch_busy(latch_busy), .disp_on(disp_on),
  .cfg({link_mode, int_bias, addr_rst_en, latch_flag, disp_on, frame_code,
        duty_code, latch_mode, addr_hold, wr_mode}),
  .grp_addr(grp_addr), .duty_code(duty_code), .addr_hold(addr_hold),
  .wr_mode(wr_mode), .ram_we(ram_we)
);

// File: tb/lcd_host_if_bench.sv
module lcd_host_if_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1, stb_n = 1'b1, sclk = 1'b0, sdin = 1'b0, latch_busy = 1'b0;
  logic [5:0] rd_addr = '0, grp_addr;
  logic [7:0] rd_data;
  logic [1:0] frame_code, duty_code, wr_mode, link_mode;
  logic       latch_mode, addr_hold, int_bias, addr_rst_en, latch_flag, disp_on, data_seen;
  int         n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_host_if u_lcd_host_if (
    .clk(clk), .rst(rst), .stb_n(stb_n), .sclk(sclk), .sdin(sdin), .latch_busy(latch_busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_code(frame_code), .duty_code(duty_code),
    .latch_mode(latch_mode), .addr_hold(addr_hold), .wr_mode(wr_mode), .link_mode(link_mode),
    .int_bias(int_bias), .addr_rst_en(addr_rst_en), .latch_flag(latch_flag),
    .disp_on(disp_on), .grp_addr(grp_addr), .data_seen(data_seen)
  );

  // {command byte, expected flags: link(2) bias arst lflag on frame(2) duty(2) lmode hold wmode(2)}
  localparam logic [21:0] VEC [6] = '{
    {8'b0000_0111, 14'b00_0000_0111_0000},
    {8'b0100_1101, 14'b00_0000_0111_1101},
    {8'b1001_1011, 14'b01_1011_0111_1101},
    {8'b0011_1010, 14'b01_1011_1010_1101},
    {8'b0111_0000, 14'b01_1011_1010_0000},
    {8'b1000_0100, 14'b00_0100_1010_0000}
  };

  function automatic logic [13:0] cfg_now();
    return {link_mode, int_bias, addr_rst_en, latch_flag, disp_on, frame_code,
            duty_code, latch_mode, addr_hold, wr_mode};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, input bit cut);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0;
      sdin = b[7-i];
      tick(2);
      sclk = 1'b1;
      tick((cut && i == nb - 1) ? 1 : 2);
    end
  endtask

  task automatic open_win();
    stb_n = 1'b0;
    tick(2);
  endtask

  task automatic close_win();
    sclk  = 1'b0;
    stb_n = 1'b1;
    tick(3);
  endtask

  task automatic xfer1(input logic [7:0] b);
    open_win();
    send_bits(b, 8, 1'b0);
    close_win();
  endtask

  task automatic read_at(input logic [5:0] a);
    rd_addr = a;
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [13:0] saved;
    tick(4);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check(cfg_now(), 14'h0, "R1 flags");
    check(grp_addr, 0, "R1 grp_addr");
    check(data_seen, 0, "R1 data_seen");

    // R3 R4 R5 R6 table walk
    foreach (VEC[i]) begin
      xfer1(VEC[i][21:14]);
      check(cfg_now(), VEC[i][13:0], "R3/R4/R5/R6 table");
    end

    xfer1(8'h80);
    check(cfg_now(), 14'b00_0000_1010_0000, "R6 clear");

    // R8 R9 R13: address 18, two bytes, wrap at 19 (duty 10)
    open_win();
    send_bits(8'hD2, 8, 1'b0);
    check(grp_addr, 18, "R7 load 18");
    send_bits(8'hAA, 8, 1'b0);
    send_bits(8'h55, 8, 1'b0);
    check(grp_addr, 0, "R9 wrap at 19");
    check(data_seen, 1, "R13 data_seen set");
    close_win();
    check(data_seen, 0, "R13 data_seen clear");
    read_at(6'd18);
    check(rd_data, 8'hAA, "R8 read 18");
    read_at(6'd19);
    check(rd_data, 8'h55, "R8 read 19");

    // R7 clamp
    xfer1(8'hC5);
    check(grp_addr, 5, "R7 load 5");
    xfer1(8'hD4);
    check(grp_addr, 0, "R7 clamp 20");

    // R9 hold
    xfer1(8'h44);
    open_win();
    send_bits(8'hC3, 8, 1'b0);
    send_bits(8'h11, 8, 1'b0);
    send_bits(8'h22, 8, 1'b0);
    close_win();
    check(grp_addr, 3, "R9 hold");
    read_at(6'd3);
    check(rd_data, 8'h22, "R8 hold write");

    // R5 prohibited write mode
    xfer1(8'h40);
    open_win(); send_bits(8'hC7, 8, 1'b0); send_bits(8'h3C, 8, 1'b0); close_win();
    check(grp_addr, 8, "R9 advance");
    xfer1(8'h42);
    open_win(); send_bits(8'hC7, 8, 1'b0); send_bits(8'hC3, 8, 1'b0); close_win();
    check(grp_addr, 7, "R5 no advance");
    read_at(6'd7);
    check(rd_data, 8'h3C, "R5 no write");

    // R10 address reset after write
    xfer1(8'h40);
    xfer1(8'h84);
    open_win();
    send_bits(8'hCA, 8, 1'b0);
    send_bits(8'h77, 8, 1'b0);
    check(grp_addr, 11, "R9 advance to 11");
    close_win();
    check(grp_addr, 0, "R10 reset on rise");
    xfer1(8'hCA);
    check(grp_addr, 10, "R10 no write no reset");

    // R12 strobe edge on pending byte
    xfer1(8'h81);
    check(disp_on, 1, "R6 on");
    open_win();
    send_bits(8'h89, 8, 1'b1);
    stb_n = 1'b1;
    tick(3);
    check(disp_on, 0, "R12 abort on");
    check(int_bias, 0, "R12 byte dropped");

    // R12 strobe edge during latch
    xfer1(8'h81);
    latch_busy = 1'b1;
    stb_n = 1'b0;
    tick(2);
    check(disp_on, 0, "R12 latch busy");
    stb_n = 1'b1;
    latch_busy = 1'b0;
    tick(2);

    // R11 partial byte discarded
    open_win();
    send_bits(8'h80, 5, 1'b0);
    close_win();
    xfer1(8'h81);
    check(disp_on, 1, "R11 realigned on");
    check(addr_rst_en, 0, "R11 realigned arst");

    // R2 shift clocks with strobe high
    saved = cfg_now();
    send_bits(8'hFF, 8, 1'b0);
    sclk = 1'b0;
    tick(2);
    check(cfg_now(), saved, "R2 ignored flags");
    check(grp_addr, 10, "R2 ignored addr");
    xfer1(8'h01);
    check(cfg_now(), 14'b00_0001_0001_0000, "R2 R4 mode after idle clocks");

    // R7 R9 duty 01 limit 14
    open_win();
    send_bits(8'hCE, 8, 1'b0);
    send_bits(8'h5A, 8, 1'b0);
    check(grp_addr, 0, "R9 wrap at 14");
    close_win();
    xfer1(8'hCA);
    check(grp_addr, 10, "R7 load 10");
    xfer1(8'hCF);
    check(grp_addr, 0, "R7 clamp 15");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule